// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns bytes into an asynchronous serial bit stream. A byte written into a one-entry holding register moves into a shift register on the next bit-timing tick. It then leaves on the line as a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or more high stop bits. The idle line is high.

A seven-bit line control word sets the frame format and break forcing. A baud divisor sets the bit rate: the divisor produces a tick every `baud_div` clock cycles, and every bit lasts `OVS` ticks, 16 by default. Two flags report whether the holding register and the shifter are free. A driver uses these flags to keep frames back to back, with no idle gap between them.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset `txd` is 1 and both `hold_empty` and `shift_empty` are 1. While the shifter is idle and break is off, `txd` stays 1.
- R2: A frame is a start bit (0), then the data bits LSB first, then optional parity, then stop bits (1). Each bit lasts 16 ticks. A tick occurs every `baud_div` clock cycles, and a `baud_div` of 0 acts as 1.
- R3: Bits 1:0 of `line_ctl` set the word length: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits. Unused high bits of `wr_data` are not sent.
- R4: Bits 4:3 of `line_ctl` set parity: x0 gives none, 01 gives odd (data plus parity hold an odd number of ones) and 11 gives even.
- R5: With parity on and bit 5 of `line_ctl` set, the parity bit is a constant: 1 when odd is selected and 0 when even is selected.
- R6: With bit 2 of `line_ctl` clear, the stop time is 16 ticks. With it set, the stop time is 24 ticks for 5-bit words and 32 ticks for other lengths.
- R7: While bit 6 of `line_ctl` is 1, `txd` is 0 from the same cycle on. The shifter keeps its timing underneath, and `txd` resumes the frame once break clears.
- R8: `hold_empty` is 0 on the cycle after `wr_en`. It returns to 1 when the shifter takes the byte. A write while the holding register is full replaces the waiting byte.
- R9: `shift_empty` is 0 from the load of a byte until the end of its last stop bit. A byte waiting at that point starts its start bit with no idle gap.
- R10: The format (bits 5:0) is captured when a byte is loaded. A change to it during a frame applies only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write `wr_data` into the holding register |
| wr_data | input | 8 | Byte to send |
| line_ctl | input | 7 | Frame format and break control |
| baud_div | input | DIV_W | Clock cycles per tick |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register free |
| shift_empty | output | 1 | Shifter idle |

## Verification
The bench sends pairs of bytes back to back and checks two things at the frame boundary. One cycle before the next start bit, the line must still be high. A design with a wrong stop length, or with a missing half stop for 5-bit words, would start early or late. Mid-frame changes to the format show whether the design latched the format at load; a design that did not would send the rest of the frame with the new settings. Constant-parity, divisor-zero, pending-byte replacement and break cases are aimed at a design that would send computed parity, stall on a zero divisor, keep the stale byte, or stop its timing during a break.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam int LC_STOP   = 2;
   localparam int LC_PAR_EN = 3;
   localparam int LC_EVEN   = 4;
   localparam int LC_STICK  = 5;
   localparam int LC_BRK    = 6;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_PAR,
      TX_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] len;
      logic       stop_long;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
   } frame_fmt_t;

   function automatic frame_fmt_t decode_fmt(input logic [6:0] c);
      frame_fmt_t f;
      f.len       = c[1:0];
      f.stop_long = c[LC_STOP];
      f.par_en    = c[LC_PAR_EN];
      f.par_even  = c[LC_EVEN];
      f.par_stick = c[LC_STICK];
      return f;
   endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim = (div == '0) ? '0 : div - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + DIV_W'(1);
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity (
   input  logic [7:0] data,
   input  logic [1:0] len,
   input  logic       even,
   input  logic       stick,
   output logic       bit_out
);
   logic [7:0] mask;
   logic [7:0] used;

   assign mask = 8'hFF >> (2'd3 - len);
   assign used = data & mask;

   always_comb begin
      if (stick)     bit_out = ~even;
      else if (even) bit_out = ^used;
      else           bit_out = ~(^used);
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic [6:0] line_ctl,
   output logic       line_bit,
   output logic       hold_full,
   output logic       busy
);
   localparam int TW   = $clog2(2 * OVS);
   localparam int HALF = OVS / 2;

   tx_state_e  st;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] stop_last;
   logic [7:0] thr;
   logic [7:0] sr;
   logic [2:0] left;
   frame_fmt_t fmt;
   frame_fmt_t new_fmt;
   logic       par_q;
   logic       par_new;
   logic       bit_end;
   logic       stop_end;
   logic       load;

   assign new_fmt = decode_fmt(line_ctl);

   sertx_parity u_par (
      .data    (thr),
      .len     (new_fmt.len),
      .even    (new_fmt.par_even),
      .stick   (new_fmt.par_stick),
      .bit_out (par_new)
   );

   always_comb begin
      if (!fmt.stop_long)    stop_last = TW'(OVS - 1);
      else if (fmt.len == 0) stop_last = TW'(OVS + HALF - 1);
      else                   stop_last = TW'(2 * OVS - 1);
   end

   assign bit_end  = (tcnt == TW'(OVS - 1));
   assign stop_end = (st == TX_STOP) && (tcnt == stop_last);
   assign load     = tick && hold_full && ((st == TX_IDLE) || stop_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr       <= '0;
         hold_full <= 1'b0;
      end else if (wr_en) begin
         thr       <= wr_data;
         hold_full <= 1'b1;
      end else if (load) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         tcnt  <= '0;
         sr    <= '0;
         left  <= '0;
         fmt   <= '0;
         par_q <= 1'b0;
      end else if (load) begin
         st    <= TX_START;
         tcnt  <= '0;
         sr    <= thr;
         left  <= 3'd4 + {1'b0, new_fmt.len};
         fmt   <= new_fmt;
         par_q <= par_new;
      end else if (tick) begin
         case (st)
            TX_START: begin
               tcnt <= bit_end ? '0 : tcnt + TW'(1);
               if (bit_end) st <= TX_DATA;
            end
            TX_DATA: begin
               tcnt <= bit_end ? '0 : tcnt + TW'(1);
               if (bit_end) begin
                  sr <= sr >> 1;
                  if (left == 3'd0) st <= fmt.par_en ? TX_PAR : TX_STOP;
                  else              left <= left - 3'd1;
               end
            end
            TX_PAR: begin
               tcnt <= bit_end ? '0 : tcnt + TW'(1);
               if (bit_end) st <= TX_STOP;
            end
            TX_STOP: begin
               tcnt <= stop_end ? '0 : tcnt + TW'(1);
               if (stop_end) st <= TX_IDLE;
            end
            default: tcnt <= '0;
         endcase
      end
   end

   always_comb begin
      case (st)
         TX_START: line_bit = 1'b0;
         TX_DATA:  line_bit = sr[0];
         TX_PAR:   line_bit = par_q;
         default:  line_bit = 1'b1;
      endcase
   end

   assign busy = (st != TX_IDLE);
endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
   import sertx_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int OVS     = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic [6:0]       line_ctl,
   input  logic [DIV_W-1:0] baud_div,
   output logic             txd,
   output logic             hold_empty,
   output logic             shift_empty
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic tick;
   logic line_bit;
   logic hold_full;
   logic busy;
   logic line_out;

   sertx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (baud_div),
      .tick (tick)
   );

   sertx_shifter #(.OVS(OVS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .line_ctl (line_ctl),
      .line_bit (line_bit),
      .hold_full(hold_full),
      .busy     (busy)
   );

   assign line_out = line_ctl[LC_BRK] ? 1'b0 : line_bit;

   if (OUT_REG) begin : g_out_reg
      logic txd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txd_q <= 1'b1;
         else        txd_q <= line_out;
      end
      assign txd = txd_q;
   end else begin : g_out_comb
      assign txd = line_out;
   end

   assign hold_empty  = ~hold_full;
   assign shift_empty = ~busy;
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [6:0] line_ctl,
   input logic       txd,
   input logic       hold_empty,
   input logic       shift_empty
);
   a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty);

   a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      line_ctl[6] && $past(line_ctl[6]) |-> !txd);

   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty && $past(shift_empty) && !line_ctl[6] && !$past(line_ctl[6]) |-> txd);

   a_r9_load_from_holding: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |-> $past(!hold_empty));

   a_r9_stop_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shift_empty) && !$past(line_ctl[6]) && !$past(line_ctl[6], 2) |-> $past(txd));
endmodule

bind serial_tx_framer sertx_checks u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .line_ctl   (line_ctl),
   .txd        (txd),
   .hold_empty (hold_empty),
   .shift_empty(shift_empty)
);

// File: tb/sim_serial_tx_framer.sv
module sim_serial_tx_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [6:0]  line_ctl = 7'h03;
   logic [15:0] baud_div = 16'd1;
   logic        txd;
   logic        hold_empty;
   logic        shift_empty;

   int checks = 0;
   int errors = 0;
   int pos = 0;
   int cyc = 0;

   serial_tx_framer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .line_ctl(line_ctl), .baud_div(baud_div), .txd(txd),
      .hold_empty(hold_empty), .shift_empty(shift_empty)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int nbits(input logic [6:0] c);
      return 5 + int'(c[1:0]);
   endfunction

   function automatic int stop_ticks(input logic [6:0] c);
      if (!c[2]) return 16;
      return (c[1:0] == 2'b00) ? 24 : 32;
   endfunction

   function automatic int frame_cycles(input logic [6:0] c, input int d);
      return d * (16 * (1 + nbits(c) + int'(c[3])) + stop_ticks(c));
   endfunction

   function automatic logic exp_bit(input logic [7:0] d, input logic [6:0] c, input int k);
      int n = nbits(c);
      logic p = 1'b0;
      for (int i = 0; i < n; i++) p = p ^ d[i];
      if (k == 0) return 1'b0;
      if (k <= n) return d[k-1];
      if (c[5]) return ~c[4];
      return c[4] ? p : ~p;
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      pos += n;
   endtask

   task automatic go_to(input int t);
      if (t > pos) step(t - pos);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_data = d;
      wr_en = 1'b1;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic wait_fall();
      bit found = 0;
      for (int i = 0; i < 4000; i++) begin
         if (!txd) begin found = 1; break; end
         @(negedge clk);
      end
      if (!found) check("R2 start bit seen", 0, 1);
      pos = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000; i++) begin
         if (shift_empty && hold_empty) break;
         @(negedge clk);
      end
   endtask

   task automatic check_bits(input logic [7:0] d, input logic [6:0] c, input int dv);
      int nb = 1 + nbits(c) + int'(c[3]);
      for (int k = 0; k < nb; k++) begin
         go_to(16 * dv * k + 8 * dv);
         if (k == 0)             check("R2 start bit", int'(txd), 0);
         else if (k <= nbits(c)) check("R3 data bit", int'(txd), int'(exp_bit(d, c, k)));
         else if (c[5])          check("R5 stick parity", int'(txd), int'(exp_bit(d, c, k)));
         else                    check("R4 parity bit", int'(txd), int'(exp_bit(d, c, k)));
      end
      go_to(16 * dv * nb + 8 * dv);
      check("R2 stop bit high", int'(txd), 1);
      go_to(frame_cycles(c, dv) - 1);
      check("R6 stop length end", int'(txd), 1);
   endtask

   task automatic run_pair(input logic [7:0] da, input logic [6:0] ca,
                           input logic [7:0] db, input logic [6:0] cb, input int dv);
      baud_div = 16'(dv);
      line_ctl = ca;
      wait_idle();
      wr(da);
      wait_fall();
      line_ctl = cb;           // R10 format change mid-frame
      wr(db);
      check("R8 holding full after write", int'(hold_empty), 0);
      check_bits(da, ca, (dv == 0) ? 1 : dv);
      go_to(frame_cycles(ca, (dv == 0) ? 1 : dv));
      check("R9 back-to-back start", int'(txd), 0);
      check("R8 holding freed at load", int'(hold_empty), 1);
      pos = 0;
      check_bits(db, cb, (dv == 0) ? 1 : dv);
      go_to(frame_cycles(cb, (dv == 0) ? 1 : dv));
      check("R9 shifter idle after frame", int'(shift_empty), 1);
      check("R1 idle line high", int'(txd), 1);
   endtask

   initial begin
      void'($urandom(32'd1234));
      step(3);
      check("R1 txd at reset", int'(txd), 1);
      check("R1 hold_empty at reset", int'(hold_empty), 1);
      check("R1 shift_empty at reset", int'(shift_empty), 1);
      rst_n = 1'b1;
      step(5);
      check("R1 idle after reset", int'(txd), 1);

      // directed: 5 bits, 1.5 stop, odd parity
      run_pair(8'hF5, 7'h0C, 8'h3A, 7'h1B, 1);
      // stick parity both polarities, 8 bits
      run_pair(8'hA7, 7'h2B, 8'h01, 7'h3F, 2);
      // divisor 0 acts as 1
      run_pair(8'h5C, 7'h07, 8'hC3, 7'h00, 0);

      // R8 replacement of pending byte
      baud_div = 16'd1;
      line_ctl = 7'h03;
      wait_idle();
      wr(8'h11);
      wait_fall();
      wr(8'h22);
      wr(8'h9E);
      check_bits(8'h11, 7'h03, 1);
      go_to(frame_cycles(7'h03, 1));
      pos = 0;
      check_bits(8'h9E, 7'h03, 1);   // R8 replaced byte sent

      // R7 break while idle
      wait_idle();
      line_ctl = 7'h43;
      #1;
      check("R7 break immediate", int'(txd), 0);
      step(5);
      check("R7 break held", int'(txd), 0);
      line_ctl = 7'h03;
      #1;
      check("R7 break release", int'(txd), 1);

      // R7 break mid-frame, timing continues
      step(2);
      wr(8'h00);
      wait_fall();
      go_to(20);
      line_ctl = 7'h43;
      go_to(40);
      check("R7 break during frame", int'(txd), 0);
      go_to(frame_cycles(7'h03, 1) - 1);
      check("R7 break over stop", int'(txd), 0);
      line_ctl = 7'h03;
      go_to(frame_cycles(7'h03, 1) + 1);
      check("R7 shifter kept timing", int'(shift_empty), 1);
      check("R7 line back high", int'(txd), 1);

      // random pairs
      for (int it = 0; it < 40; it++) begin
         logic [7:0] a = 8'($urandom);
         logic [7:0] b = 8'($urandom);
         logic [6:0] ca = 7'($urandom) & 7'h3F;
         logic [6:0] cb = 7'($urandom) & 7'h3F;
         run_pair(a, ca, b, cb, 1 + int'($urandom % 3));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule